// File: doc/BRIEF.md
# Loadable Synchronous Counter with Modulus Configurations

This block is a 4-bit synchronous binary counter cell together with a wrapper that builds fixed-modulus and wider counters out of copies of that cell. Each cell updates only on the common clock edge. It has a synchronous active-low clear, an active-low parallel load, two count enables that must both be high for the count to advance, and a carry output that flags the terminal count.

The wrapper contains one free-standing cell, which the top-level ports drive directly, and three prebuilt setups. The first is a modulus-11 counter: its carry drives its own load input, and the preset is 5. The second is a decade counter that reloads zero after nine. The third is an 8-bit counter made of two cells, where the low cell's carry is the high cell's trickle enable. All three prebuilt setups advance while `run` is high and hold while it is low. The block-level synchronous reset `rst_n` clears every cell.

Top module: `sync_cnt_top`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, every count (`q`, `mod11_q`, `dec_q`, `chain_q`) becomes 0 at that edge.
- R2: With `rst_n` high and `clr_n` low at an edge, `q` becomes 0, whatever the values of `ld_n`, `din` and the enables.
- R3: With `clr_n` high and `ld_n` low at an edge, `q` takes the value of `din`, whether or not the enables are high.
- R4: With `clr_n` and `ld_n` high, `q` advances by one, wrapping from 15 to 0, only when `en_p` and `en_t` are both high. Otherwise `q` holds.
- R5: `rco` is high exactly when `en_t` is high and `q` equals 15. It follows its inputs within the same cycle.
- R6: `mod11_q` counts up by one each `run` cycle, and after 15 it returns to 5, so it follows an 11-state cycle 5..15. `mod11_wrap` is high exactly when `run` is high and `mod11_q` is 15.
- R7: `dec_q` counts 0..9 and then returns to 0, one step per `run` cycle. `dec_wrap` is high exactly when `run` is high and `dec_q` is 9.
- R8: `chain_q` is {high stage, low stage}. It advances as an 8-bit binary count by one per `run` cycle, and the high nibble steps once for every 16 steps of the low nibble. `chain_rco` is high exactly when `run` is high and `chain_q` is 255.
- R9: While `run` is low, `mod11_q`, `dec_q` and `chain_q` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock for every cell |
| rst_n | input | 1 | Synchronous active-low reset for the whole block |
| clr_n | input | 1 | Synchronous active-low clear of the free-standing cell |
| ld_n | input | 1 | Active-low parallel load of the free-standing cell |
| din | input | 4 | Load value of the free-standing cell |
| en_p | input | 1 | Count enable (not gating carry) |
| en_t | input | 1 | Count enable that also gates `rco` |
| q | output | 4 | Count of the free-standing cell |
| rco | output | 1 | Carry of the free-standing cell |
| run | input | 1 | Advance enable for the three prebuilt setups |
| mod11_q | output | 4 | Count of the modulus-11 setup |
| mod11_wrap | output | 1 | Terminal-count flag of the modulus-11 setup |
| dec_q | output | 4 | Count of the decade setup |
| dec_wrap | output | 1 | Terminal-count flag of the decade setup |
| chain_q | output | 8 | Count of the two-stage cascade |
| chain_rco | output | 1 | Carry out of the cascade |

## Verification
Any wrong cell state shows on a count port at the very next edge, because every count is a port and every next state is a pure function of the present state and the inputs. A faulty carry gate or a faulty priority between clear, load and enable shows either on `rco` in the same cycle or on `q` one edge later. In the feedback setups a wrong reload value or reload moment changes the sequence at the first wrap. The reference model is compared on every clock, so such a fault is reported within one cycle of the wrap.

// File: rtl/sync_cnt_pkg.sv
// Shared widths and the configuration selector for the counter family.
package sync_cnt_pkg;
    localparam int CELL_W = 4;

    typedef enum logic [0:0] {
        MOD_CARRY_RELOAD = 1'b0,   // reload preset when the carry fires
        MOD_VALUE_RELOAD = 1'b1    // reload preset after a chosen last value
    } mod_mode_e;
endpackage

// File: rtl/sync_cnt_cell.sv
// Counter cell: W-bit synchronous binary counter.
// Priority at the edge: clear, then load, then count (needs both enables).
// Assumes every input is synchronous to clk. Carry is gated by en_t.
module sync_cnt_cell #(
    parameter int W = sync_cnt_pkg::CELL_W
) (
    input  logic         clk,
    input  logic         clr_n,
    input  logic         ld_n,
    input  logic [W-1:0] din,
    input  logic         en_p,
    input  logic         en_t,
    output logic [W-1:0] q,
    output logic         tc
);
    localparam logic [W-1:0] TOP = '1;

    logic [W-1:0] q_r;

    // State update, with clear above load above counting.
    always_ff @(posedge clk) begin
        if (!clr_n)
            q_r <= '0;
        else if (!ld_n)
            q_r <= din;
        else if (en_p && en_t)
            q_r <= q_r + 1'b1;
    end

    // Terminal-count carry, gated by the trickle enable.
    always_comb begin
        tc = en_t && (q_r == TOP);
    end

    assign q = q_r;
endmodule

// File: rtl/sync_cnt_modulo.sv
// Fixed-modulus counter built from one cell, with load feedback.
// MOD_CARRY_RELOAD: the carry drives the load, so after the top value comes PRESET.
// MOD_VALUE_RELOAD: the load fires once the count reaches LAST, so after LAST comes PRESET.
// Assumes rst_n is synchronous. The count advances only while run is high.
module sync_cnt_modulo #(
    parameter int                     W      = sync_cnt_pkg::CELL_W,
    parameter sync_cnt_pkg::mod_mode_e MODE  = sync_cnt_pkg::MOD_CARRY_RELOAD,
    parameter logic [W-1:0]           PRESET = '0,
    parameter logic [W-1:0]           LAST   = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    output logic [W-1:0] q,
    output logic         wrap
);
    logic [W-1:0] cnt;
    logic         carry;

    sync_cnt_cell #(.W(W)) cell_i (
        .clk  (clk),
        .clr_n(rst_n),
        .ld_n (~wrap),
        .din  (PRESET),
        .en_p (run),
        .en_t (run),
        .q    (cnt),
        .tc   (carry)
    );

    generate
        if (MODE == sync_cnt_pkg::MOD_CARRY_RELOAD) begin : g_carry
            // Reload request comes straight from the cell carry.
            always_comb wrap = carry;
        end else begin : g_value
            // Reload at LAST or above; the carry term also covers the top value.
            always_comb wrap = (run && (cnt >= LAST)) || carry;
        end
    endgenerate

    assign q = cnt;
endmodule

// File: rtl/sync_cnt_chain.sv
// Cascade of STAGES cells. Each stage's carry is the next stage's trickle enable.
// run feeds the parallel enable of every stage and the trickle enable of stage 0.
// Assumes rst_n is synchronous. No stage uses its load input.
module sync_cnt_chain #(
    parameter int W      = sync_cnt_pkg::CELL_W,
    parameter int STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    output logic [TOT_W-1:0]  q,
    output logic              rco
);
    localparam int TOT_W = W * STAGES;

    logic [STAGES:0] link;

    assign link[0] = run;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            sync_cnt_cell #(.W(W)) cell_i (
                .clk  (clk),
                .clr_n(rst_n),
                .ld_n (1'b1),
                .din  ({W{1'b0}}),
                .en_p (run),
                .en_t (link[s]),
                .q    (q[s*W +: W]),
                .tc   (link[s+1])
            );
        end
    endgenerate

    assign rco = link[STAGES];
endmodule

// File: rtl/sync_cnt_top.sv
// Top: one free-standing cell driven from the ports, plus a modulus-11 setup,
// a decade setup and a two-stage cascade. rst_n is a synchronous active-low
// reset that clears every cell. Assumes every input is synchronous to clk.
module sync_cnt_top #(
    parameter int W = sync_cnt_pkg::CELL_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clr_n,
    input  logic           ld_n,
    input  logic [W-1:0]   din,
    input  logic           en_p,
    input  logic           en_t,
    output logic [W-1:0]   q,
    output logic           rco,
    input  logic           run,
    output logic [W-1:0]   mod11_q,
    output logic           mod11_wrap,
    output logic [W-1:0]   dec_q,
    output logic           dec_wrap,
    output logic [2*W-1:0] chain_q,
    output logic           chain_rco
);
    logic cell_clr_n;

    // The block reset also acts as a clear for the free-standing cell.
    always_comb cell_clr_n = rst_n && clr_n;

    sync_cnt_cell #(.W(W)) free_i (
        .clk  (clk),
        .clr_n(cell_clr_n),
        .ld_n (ld_n),
        .din  (din),
        .en_p (en_p),
        .en_t (en_t),
        .q    (q),
        .tc   (rco)
    );

    sync_cnt_modulo #(
        .W(W), .MODE(sync_cnt_pkg::MOD_CARRY_RELOAD),
        .PRESET(W'(5)), .LAST('1)
    ) mod11_i (
        .clk(clk), .rst_n(rst_n), .run(run), .q(mod11_q), .wrap(mod11_wrap)
    );

    sync_cnt_modulo #(
        .W(W), .MODE(sync_cnt_pkg::MOD_VALUE_RELOAD),
        .PRESET('0), .LAST(W'(9))
    ) dec_i (
        .clk(clk), .rst_n(rst_n), .run(run), .q(dec_q), .wrap(dec_wrap)
    );

    sync_cnt_chain #(.W(W), .STAGES(2)) chain_i (
        .clk(clk), .rst_n(rst_n), .run(run), .q(chain_q), .rco(chain_rco)
    );
endmodule

// File: rtl/sync_cnt_chk.sv
// Checker for sync_cnt_top, attached with bind. It watches only the top ports.
module sync_cnt_chk #(
    parameter int W = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic           clr_n,
    input logic           ld_n,
    input logic [W-1:0]   din,
    input logic           en_p,
    input logic           en_t,
    input logic [W-1:0]   q,
    input logic           rco,
    input logic           run,
    input logic [W-1:0]   mod11_q,
    input logic           mod11_wrap,
    input logic [W-1:0]   dec_q,
    input logic           dec_wrap,
    input logic [2*W-1:0] chain_q,
    input logic           chain_rco
);
    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_n |=> q == '0); // R2
    AST_LOAD_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        clr_n && !ld_n |=> q == $past(din)); // R3
    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        clr_n && ld_n && en_p && en_t |=> q == W'($past(q) + 1'b1)); // R4
    AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        clr_n && ld_n && !(en_p && en_t) |=> $stable(q)); // R4
    AST_CARRY_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        rco |-> en_t && q == '1); // R5
    AST_CARRY_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
        en_t && q == '1 |-> rco); // R5
    AST_MOD11_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        run && mod11_q == '1 |=> mod11_q == W'(5)); // R6
    AST_DEC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        dec_q <= W'(9)); // R7
    AST_DEC_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        run && dec_q == W'(9) |=> dec_q == '0); // R7
    AST_CHAIN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        run |=> chain_q == (2*W)'($past(chain_q) + 1'b1)); // R8
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> $stable(mod11_q) && $stable(dec_q) && $stable(chain_q)); // R9
endmodule

bind sync_cnt_top sync_cnt_chk #(.W(W)) chk_i (.*);

// File: tb/sync_cnt_top_tb_top.sv
`timescale 1ns/1ps
// Bench: behavioural integer reference model, compared at every falling edge.
module sync_cnt_top_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0, clr_n = 1'b1, ld_n = 1'b1, en_p = 1'b0, en_t = 1'b0, run = 1'b0;
    logic [3:0] din = '0;
    logic [3:0] q, mod11_q, dec_q;
    logic [7:0] chain_q;
    logic       rco, mod11_wrap, dec_wrap, chain_rco;

    int checks = 0, errors = 0;
    int mq = 0, m11 = 0, md = 0, mc = 0;
    string q_tag = "R1", cfg_tag = "R1";
    bit done = 0;
    logic [15:0] lf = 16'hACE1;

    always #2.5 clk = ~clk;

    sync_cnt_top dut_i (.*);

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // One clock: update the model at the edge, then compare at the falling edge.
    task automatic step();
        @(posedge clk);
        if (!rst_n) begin
            mq = 0; m11 = 0; md = 0; mc = 0; q_tag = "R1"; cfg_tag = "R1";
        end else begin
            if (!clr_n)              begin mq = 0;               q_tag = "R2"; end
            else if (!ld_n)          begin mq = din;             q_tag = "R3"; end
            else if (en_p && en_t)   begin mq = (mq + 1) % 16;   q_tag = "R4"; end
            else                     q_tag = "R4";
            if (run) begin
                m11 = (m11 == 15) ? 5 : m11 + 1;
                md  = (md == 9) ? 0 : md + 1;
                mc  = (mc + 1) % 256;
                cfg_tag = "";
            end else cfg_tag = "R9";
        end
        @(negedge clk);
        chk(q_tag, q, mq);
        chk(cfg_tag == "" ? "R6" : cfg_tag, mod11_q, m11);
        chk(cfg_tag == "" ? "R7" : cfg_tag, dec_q, md);
        chk(cfg_tag == "" ? "R8" : cfg_tag, chain_q, mc);
    endtask

    // Combinational outputs checked against the current inputs, away from the edge.
    task automatic comb_chk();
        #0.5;
        chk("R5", rco, (en_t && mq == 15) ? 1 : 0);
        chk("R6", mod11_wrap, (run && m11 == 15) ? 1 : 0);
        chk("R7", dec_wrap, (run && md == 9) ? 1 : 0);
        chk("R8", chain_rco, (run && mc == 255) ? 1 : 0);
    endtask

    task automatic drive(input logic c, input logic l, input logic [3:0] d,
                         input logic p, input logic t, input logic r);
        clr_n = c; ld_n = l; din = d; en_p = p; en_t = t; run = r;
        comb_chk();
        step();
    endtask

    initial begin
        @(negedge clk);
        repeat (3) step();                     // R1: reset holds everything at 0
        rst_n = 1'b1;
        drive(1, 0, 4'd14, 0, 0, 1);           // R3: load with enables off
        drive(1, 1, 4'd0, 1, 1, 1);            // R4: count to 15
        drive(1, 1, 4'd0, 1, 0, 1);            // R5: en_t low masks carry, hold
        drive(1, 1, 4'd0, 0, 1, 1);            // R5: carry high, R4 hold
        drive(1, 1, 4'd0, 1, 1, 0);            // R4 wrap to 0, R9 run low
        drive(0, 0, 4'd9, 1, 1, 0);            // R2: clear beats load
        drive(1, 0, 4'd7, 1, 1, 1);            // R3: load beats count
        for (int i = 0; i < 40; i++) drive(1, 1, 4'd0, 1, 1, 1); // R6/R7 wraps
        for (int i = 0; i < 1400; i++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            if (i == 700) rst_n = 1'b0;
            if (i == 703) rst_n = 1'b1;
            drive(lf[3:0] != 0, lf[6:4] != 0, lf[10:7], lf[11] | lf[12], lf[13] | lf[14],
                  lf[15:13] != 0);
        end
        for (int i = 0; i < 600; i++) drive(1, 1, 4'd0, 1, 1, 1); // R8 full wraps
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule